// File: doc/BRIEF.md
# Cascadable Presettable Synchronous Binary Counter

This block is a synchronous up-counter built from identical 4-bit slices. Each slice can be cleared to zero, preset from a data word, held, or advanced by one. Every change happens on the rising clock edge. The fixed priority is clear, then preset, then count. A slice counts only when both of its enables are high. One enable, `cnt_en_p`, goes to every slice in parallel. The other, `cnt_en_t`, ripples along the chain through each slice's terminal-count flag.

The top module instantiates `NUM_SLICES` slices. The carry flag of each slice feeds the trickle enable of the next, more significant slice. As a result the chain behaves as one `NUM_SLICES*SLICE_W`-bit counter with no extra glue logic. The overall terminal-count output is the flag of the most significant slice. It is combinational, so it follows the trickle enable and the current count without waiting for a clock edge.

The counter can also run with a shorter modulus. External logic decodes a chosen count and drives `clr_n` low, and the counter then returns to zero on the following edge. There is no data stream at this block's edge. All pins are plain control and status pins with no valid/ready handshake.

Top module: `cascade_counter`

## Requirements
- R1: If `clr_n` is 0 at a rising edge, `count` becomes 0, whatever the values of `load_n`, `cnt_en_p` and `cnt_en_t`.
- R2: If `clr_n` is 1 and `load_n` is 0 at a rising edge, `count` takes the value of `din`, whatever the values of both enables.
- R3: If `clr_n` and `load_n` are both 1 and both enables are 1 at a rising edge, `count` increases by one. From all ones it wraps to 0.
- R4: If `clr_n` and `load_n` are both 1 and either enable is 0 at a rising edge, `count` keeps its value.
- R5: `tc_out` is 1 exactly when `cnt_en_t` is 1 and `count` is all ones. It follows a change of `cnt_en_t` in the same cycle, without a clock edge.
- R6: Slice k (bits `k*SLICE_W` upward) advances only when every lower slice is at all ones. A carry out of one slice therefore lands in the next slice on the same edge, as in one wide binary counter.
- R7: If `clr_n` is driven low while `count` equals a chosen value M, the counter runs 0..M and reaches 0 on the edge after M. This gives modulus M+1.
- R8: `count` changes only at rising clock edges. Input changes between edges leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| clr_n | input | 1 | Synchronous clear, active low, highest priority |
| load_n | input | 1 | Synchronous preset from `din`, active low |
| cnt_en_p | input | 1 | Count enable, sent to all slices in parallel |
| cnt_en_t | input | 1 | Count enable for slice 0; also gates the terminal count |
| din | input | NUM_SLICES*SLICE_W | Preset value |
| count | output | NUM_SLICES*SLICE_W | Current count |
| tc_out | output | 1 | Terminal count of the most significant slice |

## Verification
The bench runs free counting across the slice boundaries 0x0FF→0x100 and 0xFFF→0x000. A wrong carry chain would show up here as a lost or doubled carry. It drives clear and preset together with every enable combination, which confirms the priority order. Runs with only one enable low separate the hold behaviour of the parallel enable from that of the trickle enable. The bench also toggles `cnt_en_t` mid-cycle to show that `tc_out` is combinational. A decoded clear at count 9 proves the modulus-10 sequence and that the clear lands one edge after the decode.

// File: rtl/cascade_counter_pkg.sv
package cascade_counter_pkg;
  typedef enum logic [1:0] {
    ACT_HOLD  = 2'd0,
    ACT_CLEAR = 2'd1,
    ACT_LOAD  = 2'd2,
    ACT_INC   = 2'd3
  } cnt_act_e;
endpackage

// File: rtl/cnt_action_sel.sv
module cnt_action_sel
  import cascade_counter_pkg::*;
(
  input  logic     clr_n,
  input  logic     load_n,
  input  logic     en_p,
  input  logic     en_t,
  output cnt_act_e act
);
  // Fixed priority: clear, then preset, then count.
  always_comb begin
    if (!clr_n)              act = ACT_CLEAR;
    else if (!load_n)        act = ACT_LOAD;
    else if (en_p && en_t)   act = ACT_INC;
    else                     act = ACT_HOLD;
  end
endmodule

// File: rtl/cnt_slice.sv
module cnt_slice
  import cascade_counter_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         clr_n,
  input  logic         load_n,
  input  logic         en_p,
  input  logic         en_t,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic         carry
);
  localparam logic [W-1:0] MAXV = {W{1'b1}};

  cnt_act_e     act;
  logic [W-1:0] q_r;
  logic [W-1:0] q_nxt;

  cnt_action_sel u_sel (
    .clr_n (clr_n),
    .load_n(load_n),
    .en_p  (en_p),
    .en_t  (en_t),
    .act   (act)
  );

  always_comb begin
    unique case (act)
      ACT_CLEAR: q_nxt = '0;
      ACT_LOAD:  q_nxt = d;
      ACT_INC:   q_nxt = q_r + 1'b1;
      default:   q_nxt = q_r;
    endcase
  end

  always_ff @(posedge clk) q_r <= q_nxt;

  assign q     = q_r;
  // Terminal count: gated by the trickle enable, combinational.
  assign carry = en_t && (q_r == MAXV);
endmodule

// File: rtl/cascade_counter.sv
module cascade_counter #(
  parameter int SLICE_W    = 4,
  parameter int NUM_SLICES = 3
) (
  input  logic                          clk,
  input  logic                          clr_n,
  input  logic                          load_n,
  input  logic                          cnt_en_p,
  input  logic                          cnt_en_t,
  input  logic [NUM_SLICES*SLICE_W-1:0] din,
  output logic [NUM_SLICES*SLICE_W-1:0] count,
  output logic                          tc_out
);
  localparam int TOTAL_W = NUM_SLICES * SLICE_W;

  logic [NUM_SLICES:0] chain_en;
  assign chain_en[0] = cnt_en_t;

  for (genvar k = 0; k < NUM_SLICES; k++) begin : g_slice
    cnt_slice #(.W(SLICE_W)) u_slice (
      .clk   (clk),
      .clr_n (clr_n),
      .load_n(load_n),
      .en_p  (cnt_en_p),
      .en_t  (chain_en[k]),
      .d     (din[k*SLICE_W +: SLICE_W]),
      .q     (count[k*SLICE_W +: SLICE_W]),
      .carry (chain_en[k+1])
    );
  end

  assign tc_out = chain_en[NUM_SLICES];

  logic [TOTAL_W-1:0] unused_w;
  assign unused_w = '0;
endmodule

// File: rtl/cascade_counter_chk.sv
module cascade_counter_chk #(
  parameter int SLICE_W    = 4,
  parameter int NUM_SLICES = 3
) (
  input logic                          clk,
  input logic                          clr_n,
  input logic                          load_n,
  input logic                          cnt_en_p,
  input logic                          cnt_en_t,
  input logic [NUM_SLICES*SLICE_W-1:0] din,
  input logic [NUM_SLICES*SLICE_W-1:0] count,
  input logic                          tc_out
);
  localparam int TOTAL_W = NUM_SLICES * SLICE_W;

  // The counter has no reset pin; checks start after the first clear.
  logic armed = 1'b0;
  always_ff @(posedge clk) if (!clr_n) armed <= 1'b1;

  p_clear_r1: assert property (@(posedge clk) disable iff (!armed)
    !clr_n |=> (count == '0));

  p_load_r2: assert property (@(posedge clk) disable iff (!armed)
    (clr_n && !load_n) |=> (count == $past(din)));

  p_inc_r3: assert property (@(posedge clk) disable iff (!armed)
    (clr_n && load_n && cnt_en_p && cnt_en_t)
      |=> (count == TOTAL_W'($past(count) + 1'b1)));

  p_hold_r4: assert property (@(posedge clk) disable iff (!armed)
    (clr_n && load_n && !(cnt_en_p && cnt_en_t)) |=> $stable(count));

  p_tc_full_r5: assert property (@(posedge clk) disable iff (!armed)
    tc_out |-> (cnt_en_t && (&count)));

  p_tc_gate_r5: assert property (@(posedge clk) disable iff (!armed)
    (cnt_en_t && (&count)) |-> tc_out);
endmodule

bind cascade_counter cascade_counter_chk #(
  .SLICE_W(SLICE_W), .NUM_SLICES(NUM_SLICES)
) u_chk (
  .clk(clk), .clr_n(clr_n), .load_n(load_n), .cnt_en_p(cnt_en_p),
  .cnt_en_t(cnt_en_t), .din(din), .count(count), .tc_out(tc_out)
);

// File: tb/cascade_counter_test.sv
module cascade_counter_test;
  localparam int SW = 4;
  localparam int NS = 3;
  localparam int TW = SW * NS;
  localparam logic [TW-1:0] ALL1 = {TW{1'b1}};

  logic clk = 1'b0;
  logic clr_n = 1'b1, load_n = 1'b1, en_p = 1'b0, en_t = 1'b0;
  logic [TW-1:0] din = '0;
  logic [TW-1:0] count;
  logic tc_out;

  int checks = 0;
  int fails  = 0;
  logic [TW-1:0] model = '0;
  bit done = 0;

  always #2 clk = ~clk; // 250 MHz

  cascade_counter #(.SLICE_W(SW), .NUM_SLICES(NS)) uut (
    .clk(clk), .clr_n(clr_n), .load_n(load_n), .cnt_en_p(en_p),
    .cnt_en_t(en_t), .din(din), .count(count), .tc_out(tc_out)
  );

  task automatic chk(input string req, input logic [TW-1:0] act,
                     input logic [TW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // One clock: model update from current inputs, then compare.
  task automatic step(input string req);
    @(posedge clk);
    if (!clr_n)               model = '0;
    else if (!load_n)         model = din;
    else if (en_p && en_t)    model = model + 1'b1;
    #1;
    chk(req, count, model);
    chk({req, " tc R5"}, {{(TW-1){1'b0}}, tc_out},
        {{(TW-1){1'b0}}, en_t && (model == ALL1)});
  endtask

  task automatic drive(input logic c, input logic l, input logic p,
                       input logic t, input logic [TW-1:0] d);
    clr_n = c; load_n = l; en_p = p; en_t = t; din = d;
  endtask

  initial begin
    #1;
    drive(1'b0, 1'b0, 1'b1, 1'b1, 12'hABC);
    step("reset R1");
    // R1: clear beats every other input
    drive(1'b0, 1'b0, 1'b1, 1'b1, 12'h555);
    step("R1 clear over load");
    // R2: load regardless of enables
    for (int i = 0; i < 4; i++) begin
      drive(1'b1, 1'b0, i[0], i[1], 12'h100 + 12'(i * 37));
      step("R2 load");
    end
    // R3/R6: count across slice boundary 0x0FF -> 0x100
    drive(1'b1, 1'b0, 1'b0, 1'b0, 12'h0FC);
    step("R2 preset");
    drive(1'b1, 1'b1, 1'b1, 1'b1, '0);
    for (int i = 0; i < 8; i++) step("R6 carry 0FF");
    // R4: hold with each enable low
    drive(1'b1, 1'b1, 1'b0, 1'b1, '0);
    for (int i = 0; i < 3; i++) step("R4 hold en_p low");
    drive(1'b1, 1'b1, 1'b1, 1'b0, '0);
    for (int i = 0; i < 3; i++) step("R4 hold en_t low");
    // R3/R5: wrap from all ones
    drive(1'b1, 1'b0, 1'b1, 1'b1, 12'hFFD);
    step("R2 preset near top");
    drive(1'b1, 1'b1, 1'b1, 1'b1, '0);
    for (int i = 0; i < 5; i++) step("R3 wrap");
    // R5: tc is combinational on en_t at all ones
    drive(1'b1, 1'b0, 1'b0, 1'b1, ALL1);
    step("R2 load max");
    drive(1'b1, 1'b1, 1'b0, 1'b1, '0);
    #1; chk("R5 tc high", {11'd0, tc_out}, 12'd1);
    en_t = 1'b0;
    #0.5; chk("R5 tc drop no edge", {11'd0, tc_out}, 12'd0);
    // R8: count unchanged by mid-cycle input changes
    chk("R8 stable mid-cycle", count, model);
    drive(1'b0, 1'b0, 1'b1, 1'b1, 12'h123);
    #0.4; chk("R8 no async clear", count, model);
    step("R1 clear at edge");
    // R7: modulus 10 by decoding count 9 into clear
    drive(1'b1, 1'b1, 1'b1, 1'b1, '0);
    for (int i = 0; i < 25; i++) begin
      clr_n = (model != 12'd9);
      step("R7 mod10");
    end
    // R6: full-width wrap over every slice
    drive(1'b1, 1'b0, 1'b1, 1'b1, 12'hFFE);
    step("R2 preset");
    drive(1'b1, 1'b1, 1'b1, 1'b1, '0);
    for (int i = 0; i < 4; i++) step("R6 full wrap");
    // R3: long free run through many carries
    for (int i = 0; i < 600; i++) step("R3 free run");
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule